// File: doc/BRIEF.md
# Thread-Partitionable Shared Cache Replacement

This block chooses where a new line goes in a set-associative cache that two hardware threads share. On every access it is given the set index, the issuing thread, a one-hot hit vector and the per-way valid bits. It reports a miss and, on the same cycle, names the way to fill. Recency for every set is kept inside the block as per-way age counters. Age 0 marks the most recently used way and age WAYS-1 the least recently used way.

A mode input picks between two policies. In shared mode either thread may fill any way. In partitioned mode a thread may fill only its own half of the ways. Lookups are not restricted in either mode: a hit in any way counts for both threads and refreshes that way's recency. Changing the mode leaves the stored recency alone and affects only the fills that follow. Partitioned mode is optional because it halves the capacity each thread can fill.

Top module: `tpart_repl`

## Requirements
- R1: `miss` is 1 exactly when `acc_valid` is 1 and `hit_vec` is all zero. `fill_way` is meaningful only while `miss` is 1.
- R2: In shared mode (`split_en`=0), any way of the set can be chosen as the fill way, whichever thread issued the access.
- R3: In partitioned mode (`split_en`=1), a miss from thread 0 (`acc_thread`=0) fills a way in the range 0 to WAYS/2-1. A miss from thread 1 fills a way in the range WAYS/2 to WAYS-1.
- R4: A one-hot hit in any way is reported as a hit (no miss) for either thread in either mode. The hit way becomes the most recently used way of its set.
- R5: If any allowed way of the set is invalid (its `valid_vec` bit is 0), the fill way is the lowest-indexed such way.
- R6: If every allowed way is valid, the fill way is the allowed way used least recently.
- R7: After reset, every set holds the recency order way 0 (most recent) through way WAYS-1 (least recent). A first all-valid miss therefore fills way WAYS-1 in shared mode, WAYS/2-1 for thread 0 in partitioned mode, and WAYS-1 for thread 1 in partitioned mode.
- R8: On a miss, the chosen fill way becomes the most recently used way of its set.
- R9: Changing `split_en` does not change the stored recency. Later fills follow the new mode and the recency left by earlier accesses.
- R10: A cycle with `acc_valid`=0 reports no miss and changes no recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_thread | input | 1 | Issuing thread (0 or 1) |
| split_en | input | 1 | 1 selects partitioned mode, 0 selects shared mode |
| hit_vec | input | WAYS | One-hot hit vector from the tag compare, all zero on a miss |
| valid_vec | input | WAYS | Valid bit of each way in the accessed set |
| miss | output | 1 | The access missed and needs a fill |
| fill_way | output | WAY_W | Way index to fill on a miss |

## Verification
Directed runs on a single set begin from the reset order with all ways valid. They separate the shared-mode victim from the two partitioned-mode victims. They then show that a hit from the non-owning thread in partitioned mode still reorders recency, and that a later switch back to shared mode sees that reordering. Mixed valid patterns check that an invalid allowed way wins over any recency choice, and that an invalid way outside the thread's half is ignored. A long pseudo-random stream varies set, thread, mode, hits and valid bits, and is compared every cycle against a per-set recency-list model. This separates correct per-set bookkeeping from state that leaks between sets or is lost across idle cycles.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    typedef enum logic {
        MODE_SHARED = 1'b0,
        MODE_SPLIT  = 1'b1
    } part_mode_e;

    typedef enum logic {
        THREAD_LO = 1'b0,
        THREAD_HI = 1'b1
    } thread_e;

    // Returns 1 when a way index falls in the half owned by the given thread
    function automatic logic in_owned_half(input int unsigned way_idx,
                                           input int unsigned ways,
                                           input thread_e     thr);
        if (thr == THREAD_LO) return (way_idx < ways / 2);
        else                  return (way_idx >= ways / 2);
    endfunction

endpackage

// File: rtl/tpr_allow_mask.sv
module tpr_allow_mask
    import tpr_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  part_mode_e      mode,
    input  thread_e         thr,
    output logic [WAYS-1:0] allow
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign allow[w] = (mode == MODE_SHARED) ||
                          in_owned_half(w, WAYS, thr);
    end
endmodule

// File: rtl/tpr_age_store.sv
module tpr_age_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int WAY_W = $clog2(WAYS),
    parameter int SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            rd_set,
    input  logic                        upd_en,
    input  logic [WAY_W-1:0]            upd_way,
    output logic [WAYS-1:0][WAY_W-1:0]  rd_ages
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touched_age;
    logic [WAYS-1:0]  mru_vec;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_ages[w] = age_q[rd_set][w];
            mru_vec[w] = (age_q[rd_set][w] == '0);
        end
        touched_age = age_q[rd_set][upd_way];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    age_q[rd_set][w] <= '0;
                else if (age_q[rd_set][w] < touched_age)
                    age_q[rd_set][w] <= age_q[rd_set][w] + 1'b1;
            end
        end
    end

    AST_ONE_MRU: assert property (@(posedge clk) disable iff (rst)
        $countones(mru_vec) == 1); // R7
endmodule

// File: rtl/tpr_victim_pick.sv
module tpr_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             allow,
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages,
    output logic [WAY_W-1:0]            victim,
    output logic                        took_invalid
);
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] old_way;
    logic [WAY_W-1:0] old_age;
    logic             old_found;

    always_comb begin
        took_invalid = 1'b0;
        inv_way      = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (allow[w] && !valid[w]) begin
                took_invalid = 1'b1;
                inv_way      = WAY_W'(w);
            end
        end
        old_found = 1'b0;
        old_way   = '0;
        old_age   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (allow[w] && (!old_found || ages[w] > old_age)) begin
                old_found = 1'b1;
                old_way   = WAY_W'(w);
                old_age   = ages[w];
            end
        end
        victim = took_invalid ? inv_way : old_way;
    end
endmodule

// File: rtl/tpart_repl.sv
module tpart_repl
    import tpr_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int WAY_W = $clog2(WAYS),
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_thread,
    input  logic             split_en,
    input  logic [WAYS-1:0]  hit_vec,
    input  logic [WAYS-1:0]  valid_vec,
    output logic             miss,
    output logic [WAY_W-1:0] fill_way
);
    localparam int HALF = WAYS / 2;

    part_mode_e                 mode;
    thread_e                    thr;
    logic [WAYS-1:0]            allow;
    logic [WAYS-1:0][WAY_W-1:0] ages;
    logic [WAY_W-1:0]           victim;
    logic                       took_invalid;
    logic [WAY_W-1:0]           hit_idx;
    logic                       hit_any;
    logic [WAY_W-1:0]           upd_way;

    assign mode = part_mode_e'(split_en);
    assign thr  = thread_e'(acc_thread);

    tpr_allow_mask #(.WAYS(WAYS)) u_mask (
        .mode  (mode),
        .thr   (thr),
        .allow (allow)
    );

    tpr_age_store #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_ages (
        .clk     (clk),
        .rst     (rst),
        .rd_set  (acc_set),
        .upd_en  (acc_valid),
        .upd_way (upd_way),
        .rd_ages (ages)
    );

    tpr_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .allow        (allow),
        .valid        (valid_vec),
        .ages         (ages),
        .victim       (victim),
        .took_invalid (took_invalid)
    );

    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_idx = WAY_W'(w);
    end

    assign hit_any  = |hit_vec;
    assign miss     = acc_valid && !hit_any;
    assign fill_way = victim;
    assign upd_way  = hit_any ? hit_idx : victim;

    // Count of allowed ways older than the chosen fill way (must be zero)
    logic [WAY_W:0] older_cnt;
    always_comb begin
        older_cnt = '0;
        for (int w = 0; w < WAYS; w++)
            if (allow[w] && ages[w] > ages[fill_way])
                older_cnt = older_cnt + 1'b1;
    end

    AST_SPLIT_LOWER: assert property (@(posedge clk) disable iff (rst)
        (miss && split_en && !acc_thread) |-> (fill_way < WAY_W'(HALF))); // R3
    AST_SPLIT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (miss && split_en && acc_thread) |-> (fill_way >= WAY_W'(HALF))); // R3
    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
        (miss && |(allow & ~valid_vec)) |-> !valid_vec[fill_way]); // R5
    AST_LRU_PICK: assert property (@(posedge clk) disable iff (rst)
        (miss && !took_invalid) |-> (older_cnt == '0)); // R6
endmodule

// File: tb/tb_tpart_repl.sv
module tb_tpart_repl;
    localparam int WAYS  = 4;
    localparam int SETS  = 16;
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst;
    logic             acc_valid;
    logic [SET_W-1:0] acc_set;
    logic             acc_thread;
    logic             split_en;
    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  valid_vec;
    logic             miss;
    logic [WAY_W-1:0] fill_way;

    int checks = 0;
    int errors = 0;
    int order [SETS][$];   // recency list per set, front = most recent

    always #5 clk = ~clk;

    tpart_repl #(.WAYS(WAYS), .SETS(SETS)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_thread(acc_thread), .split_en(split_en), .hit_vec(hit_vec),
        .valid_vec(valid_vec), .miss(miss), .fill_way(fill_way)
    );

    function automatic bit owned(int w, int thr, bit spl);
        if (!spl) return 1'b1;
        return thr == 0 ? (w < WAYS / 2) : (w >= WAYS / 2);
    endfunction

    task automatic touch(int s, int w);
        for (int i = 0; i < order[s].size(); i++)
            if (order[s][i] == w) begin
                order[s].delete(i);
                break;
            end
        order[s].push_front(w);
    endtask

    task automatic access(int s, int thr, bit spl, logic [WAYS-1:0] hv,
                          logic [WAYS-1:0] vv, string req);
        bit exp_miss;
        int exp_way;
        int hit_w;
        string tag;
        @(negedge clk);
        acc_valid = 1'b1; acc_set = SET_W'(s); acc_thread = thr[0];
        split_en = spl; hit_vec = hv; valid_vec = vv;
        #2;
        exp_miss = (hv == '0);
        exp_way  = -1;
        hit_w    = 0;
        for (int w = 0; w < WAYS; w++) if (hv[w]) hit_w = w;
        tag = req;
        if (exp_miss) begin
            for (int w = 0; w < WAYS; w++)
                if (exp_way < 0 && owned(w, thr, spl) && !vv[w]) exp_way = w;
            if (exp_way >= 0) begin
                if (req == "") tag = "R5";
            end else begin
                for (int i = order[s].size() - 1; i >= 0; i--)
                    if (exp_way < 0 && owned(order[s][i], thr, spl)) exp_way = order[s][i];
                if (req == "") tag = spl ? "R3" : "R6";
            end
        end else if (req == "") tag = "R4";
        checks++;
        if (miss !== exp_miss) begin
            errors++;
            $display("FAIL %s R1: miss=%0b expected %0b (set %0d)", tag, miss, exp_miss, s);
        end
        if (exp_miss) begin
            checks++;
            if (fill_way !== WAY_W'(exp_way)) begin
                errors++;
                $display("FAIL %s: fill_way=%0d expected %0d (set %0d thr %0d split %0b)",
                         tag, fill_way, exp_way, s, thr, spl);
            end
            touch(s, exp_way);
        end else touch(s, hit_w);
    endtask

    task automatic idle(int s);
        @(negedge clk);
        acc_valid = 1'b0; acc_set = SET_W'(s); hit_vec = '0;
        #2;
        checks++;
        if (miss !== 1'b0) begin
            errors++;
            $display("FAIL R10: miss=%0b expected 0 while idle", miss);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [WAYS-1:0] all1;
        all1 = '1;
        rst = 1'b1; acc_valid = 1'b0; acc_set = '0; acc_thread = 1'b0;
        split_en = 1'b0; hit_vec = '0; valid_vec = '0;
        for (int s = 0; s < SETS; s++) begin
            order[s].delete();
            for (int w = 0; w < WAYS; w++) order[s].push_back(w);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        checks++;
        if (miss !== 1'b0) begin
            errors++;
            $display("FAIL R10: miss=%0b expected 0 after reset", miss);
        end

        // R7: reset order seen through first victims of three sets
        access(1, 0, 1'b0, '0, all1, "R7");
        access(2, 0, 1'b1, '0, all1, "R7");
        access(3, 1, 1'b1, '0, all1, "R7");
        // R8: filled way becomes most recent, next victim moves on
        access(1, 1, 1'b0, '0, all1, "R8");
        // R4: thread 1 hits a way owned by thread 0 in partitioned mode
        access(1, 1, 1'b1, 4'b0001, all1, "R4");
        access(1, 0, 1'b1, '0, all1, "R4");
        // R9: back to shared mode uses recency built in partitioned mode
        access(1, 0, 1'b0, '0, all1, "R9");
        // R10: idle cycles leave recency untouched
        idle(1);
        idle(1);
        access(1, 1, 1'b0, '0, all1, "R10");
        // R5: invalid way outside own half is ignored in partitioned mode
        access(4, 0, 1'b1, '0, 4'b1011, "R5");
        access(4, 0, 1'b1, '0, 4'b1101, "R5");
        access(4, 1, 1'b0, '0, 4'b1110, "R5");
        // R2: shared mode, thread 1 may pick a lower-half way
        access(5, 1, 1'b0, '0, 4'b1100, "R2");
        // R3: upper-half fills for thread 1 over several misses
        access(6, 1, 1'b1, '0, all1, "R3");
        access(6, 1, 1'b1, '0, all1, "R3");
        access(6, 1, 1'b1, '0, all1, "R3");

        // Random stream, model compared every access
        for (int n = 0; n < 600; n++) begin
            int s, thr;
            bit spl;
            logic [WAYS-1:0] hv, vv;
            s   = $urandom_range(SETS - 1);
            thr = $urandom_range(1);
            spl = $urandom_range(1);
            hv  = '0;
            if ($urandom_range(9) < 3) hv[$urandom_range(WAYS - 1)] = 1'b1;
            vv  = '1;
            if ($urandom_range(3) == 0) vv = WAYS'($urandom);
            if ($urandom_range(7) == 0) idle(s);
            else access(s, thr, spl, hv, vv, "");
        end

        @(negedge clk);
        acc_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule